// File: doc/BRIEF.md
# External interrupt combiner

This block merges one asynchronous, active-low interrupt pin and a small group of general-purpose port pins into a single interrupt request for a CPU. Every raw pin is first brought into the clock domain through a two-flop synchronizer. Its synchronized value is then compared with its value one clock earlier to find active transitions. A detected active transition sets a pending latch, which the CPU clears with a one-cycle acknowledge strobe.

Two option bits shape the behaviour. The trigger-mode bit selects either edge-only triggering or edge-plus-level triggering. In edge-plus-level mode the request also stays up while any enabled input sits at its active level. The port-merge bit adds the port pins to the same request path with opposite polarity: a rising edge or a high level counts as active. This lets a keypad wake the CPU. The trigger mode applies to the main pin and the merged port pins alike. A CPU mask bit gates the request output, while the pending latch keeps recording edges.

Top module: `xirq_combiner`

## Requirements
- R1: While `rst` is high, and after it is released with the main pin high and all port pins low, `irq_pend` and `irq_req` stay 0.
- R2: With `cfg_level`=0, a falling edge on `irq_n_pin` sets `irq_pend` on the third rising clock edge after the pin changes. Holding the pin low afterwards does not set it again once it has been acknowledged.
- R3: With `cfg_level`=1, a low `irq_n_pin` raises `irq_req` on the second rising clock edge after the change. The request stays high while the pin stays low, even after `irq_pend` has been cleared by an acknowledge.
- R4: With `cfg_port_merge`=1, a rising edge on any `port_pin` bit sets `irq_pend`. With `cfg_level`=1 as well, a high port bit also holds `irq_req` high.
- R5: With `cfg_port_merge`=0, `port_pin` has no effect on `irq_pend` or `irq_req`, at any level or edge.
- R6: An `irq_ack` pulse clears `irq_pend` on the next clock. If a new active edge is detected in the same cycle as the acknowledge, `irq_pend` stays 1.
- R7: With `cpu_mask`=1, `irq_req` is 0, but `irq_pend` still records edges. Clearing the mask then raises `irq_req` for a pending edge.
- R8: A rising edge on `irq_n_pin` and a falling edge on a port bit never set `irq_pend`.
- R9: With `cfg_level`=0 and `cpu_mask`=0, `irq_req` equals `irq_pend`, whatever the input levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n_pin | input | 1 | Main interrupt pin, asynchronous, active low |
| port_pin | input | NPORT (4) | Port pins that can be merged, active high |
| cfg_level | input | 1 | 1 = edge-plus-level triggering, 0 = edge only |
| cfg_port_merge | input | 1 | 1 = port pins are ORed into the request path |
| cpu_mask | input | 1 | 1 = request output blocked |
| irq_ack | input | 1 | One-cycle acknowledge, clears the pending latch |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_pend | output | 1 | Pending latch state |

## Verification
The trigger logic is tried with five kinds of input: a falling and a rising main pin, rising and falling port bits with the merge bit both on and off, pins held at their active level across an acknowledge, and edges that arrive while the request is masked. These runs separate edge detection from level holding, true polarity from inverted polarity, and the merge gate from the mask gate. Directed cases then pin down the exact latency of the edge path and of the level path, an acknowledge that lands in the same cycle as a new edge, and a reset taken while an edge is pending.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int unsigned XIRQ_NPORT_DEF = 4;

    // Normalized activity of one synchronized source.
    typedef struct packed {
        logic lvl;   // source is at its active level now
        logic edg;   // source became active this cycle
    } xirq_act_t;

    // Option bits.
    typedef struct packed {
        logic level_mode;
        logic port_merge;
    } xirq_cfg_t;

    // Map a raw pin value to "active" given its polarity.
    function automatic logic xirq_norm(input logic raw, input logic act_high);
        return act_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/xirq_src.sv
module xirq_src
    import xirq_pkg::*;
#(
    parameter bit ACT_HIGH = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    output xirq_act_t act
);
    localparam logic IDLE = ~ACT_HIGH;

    logic meta, stab, stab_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= IDLE;
            stab   <= IDLE;
            stab_d <= IDLE;
        end else begin
            meta   <= raw;
            stab   <= meta;
            stab_d <= stab;
        end
    end

    logic now_act, was_act;
    assign now_act = xirq_norm(stab,   ACT_HIGH);
    assign was_act = xirq_norm(stab_d, ACT_HIGH);

    assign act.lvl = now_act;
    assign act.edg = now_act & ~was_act;

endmodule

// File: rtl/xirq_pend.sv
module xirq_pend (
    input  logic clk,
    input  logic rst,
    input  logic edge_any,
    input  logic level_any,
    input  logic level_mode,
    input  logic mask,
    input  logic ack,
    output logic pend,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= edge_any | (pend & ~ack);
    end

    assign req = ~mask & (pend | (level_mode & level_any));

endmodule

// File: rtl/xirq_combiner.sv
module xirq_combiner
    import xirq_pkg::*;
#(
    parameter int unsigned NPORT = XIRQ_NPORT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_n_pin,
    input  logic [NPORT-1:0] port_pin,
    input  logic             cfg_level,
    input  logic             cfg_port_merge,
    input  logic             cpu_mask,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic             irq_pend
);
    localparam int unsigned NSRC = NPORT + 1;

    xirq_cfg_t cfg;
    assign cfg.level_mode = cfg_level;
    assign cfg.port_merge = cfg_port_merge;

    xirq_act_t        act [NSRC];
    logic [NSRC-1:0]  src_en;
    logic             edge_any, level_any;

    // Source 0: main pin, active low.
    xirq_src #(.ACT_HIGH(1'b0)) u_main (
        .clk (clk),
        .rst (rst),
        .raw (irq_n_pin),
        .act (act[0])
    );

    // Sources 1..NPORT: port pins, active high.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        xirq_src #(.ACT_HIGH(1'b1)) u_port (
            .clk (clk),
            .rst (rst),
            .raw (port_pin[g]),
            .act (act[g+1])
        );
    end

    assign src_en = {{NPORT{cfg.port_merge}}, 1'b1};

    always_comb begin
        edge_any  = 1'b0;
        level_any = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            edge_any  = edge_any  | (act[i].edg & src_en[i]);
            level_any = level_any | (act[i].lvl & src_en[i]);
        end
    end

    xirq_pend u_pend (
        .clk        (clk),
        .rst        (rst),
        .edge_any   (edge_any),
        .level_any  (level_any),
        .level_mode (cfg.level_mode),
        .mask       (cpu_mask),
        .ack        (irq_ack),
        .pend       (irq_pend),
        .req        (irq_req)
    );

endmodule

// File: rtl/xirq_combiner_chk.sv
module xirq_combiner_chk (
    input logic clk,
    input logic rst,
    input logic cfg_level,
    input logic cpu_mask,
    input logic irq_ack,
    input logic irq_req,
    input logic irq_pend,
    input logic edge_any,
    input logic level_any
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: the clock after a reset cycle sees no pending edge
    always_ff @(posedge clk) begin
        if (rst_d == 1'b1) begin
            assert_reset_clear_R1: assert (!irq_pend);
        end
    end

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        edge_any |=> irq_pend);

    assert_level_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_level && level_any && !cpu_mask) |-> irq_req);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && irq_ack && !edge_any) |=> !irq_pend);

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_mask |-> !irq_req);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (!irq_pend && !edge_any) |=> !irq_pend);

    assert_edge_mode_req_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_level && !cpu_mask) |-> (irq_req == irq_pend));

endmodule

bind xirq_combiner xirq_combiner_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_level (cfg_level),
    .cpu_mask  (cpu_mask),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_pend  (irq_pend),
    .edge_any  (edge_any),
    .level_any (level_any)
);

// File: tb/tb_xirq_combiner.sv
module tb_xirq_combiner;

    logic       clk = 1'b0;
    logic       rst;
    logic       irq_n_pin;
    logic [3:0] port_pin;
    logic       cfg_level, cfg_port_merge, cpu_mask, irq_ack;
    logic       irq_req, irq_pend;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    xirq_combiner dut (
        .clk            (clk),
        .rst            (rst),
        .irq_n_pin      (irq_n_pin),
        .port_pin       (port_pin),
        .cfg_level      (cfg_level),
        .cfg_port_merge (cfg_port_merge),
        .cpu_mask       (cpu_mask),
        .irq_ack        (irq_ack),
        .irq_req        (irq_req),
        .irq_pend       (irq_pend)
    );

    task automatic check(input string rid, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", rid, what, act, exp);
        end
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Fields: [14:11] req id, [10] ack first, [9] level, [8] merge, [7] mask,
    //         [6] main pin, [5:2] port pins, [1] exp pend, [0] exp req
    localparam int NV = 18;
    localparam logic [14:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1}, // R2 fall
        {4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0}, // R2 held low
        {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0}, // R8 main rise
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1}, // R3 fall, level
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1}, // R3 ack, held
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0}, // R3 release
        {4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1111, 1'b0, 1'b0}, // R5 edge off
        {4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1111, 1'b0, 1'b0}, // R5 level off
        {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0}, // R8 port fall
        {4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0100, 1'b1, 1'b1}, // R4 port rise
        {4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0100, 1'b0, 1'b0}, // R4 ack edge
        {4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0}, // R8 port fall
        {4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0001, 1'b1, 1'b1}, // R4 level
        {4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0001, 1'b0, 1'b1}, // R4 held high
        {4'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b0}, // R7 masked lvl
        {4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0}, // R7 pend masked
        {4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1}, // R7 unmask
        {4'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0}  // R9 ack, idle
    };

    initial begin
        rst = 1'b1; irq_n_pin = 1'b1; port_pin = '0;
        cfg_level = 1'b0; cfg_port_merge = 1'b0; cpu_mask = 1'b0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "pend in reset", irq_pend, 1'b0);
        check("R1", "req in reset",  irq_req,  1'b0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", "pend after release", irq_pend, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            string rid;
            v = VEC[i];
            rid = $sformatf("R%0d vec%0d", v[14:11], i);
            if (v[10]) ack_pulse();
            cfg_level      = v[9];
            cfg_port_merge = v[8];
            cpu_mask       = v[7];
            irq_n_pin      = v[6];
            port_pin       = v[5:2];
            repeat (4) @(negedge clk);
            check(rid, "pend", irq_pend, v[1]);
            check(rid, "req",  irq_req,  v[0]);
        end

        // R2 latency: pending appears on third rising edge
        irq_n_pin = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", "pend after 2 edges", irq_pend, 1'b0);
        @(negedge clk);
        check("R2", "pend after 3 edges", irq_pend, 1'b1);
        ack_pulse();
        irq_n_pin = 1'b1;
        repeat (4) @(negedge clk);

        // R3 latency: level request on second rising edge
        cfg_level = 1'b1;
        irq_n_pin = 1'b0;
        @(negedge clk);
        check("R3", "req after 1 edge", irq_req, 1'b0);
        @(negedge clk);
        check("R3", "req after 2 edges", irq_req, 1'b1);
        check("R3", "pend not yet", irq_pend, 1'b0);
        irq_n_pin = 1'b1;
        repeat (4) @(negedge clk);
        ack_pulse();
        check("R3", "idle req", irq_req, 1'b0);
        cfg_level = 1'b0;

        // R6: ack in the same cycle as a fresh edge keeps pend set
        port_pin = 4'b0001;
        repeat (4) @(negedge clk);
        check("R6", "pend before ack", irq_pend, 1'b1);
        irq_n_pin = 1'b0;
        repeat (2) @(negedge clk);
        ack_pulse();
        check("R6", "pend ack+edge", irq_pend, 1'b1);

        // R1: reset while pending
        rst = 1'b1;
        irq_n_pin = 1'b1; port_pin = '0;
        repeat (2) @(negedge clk);
        check("R1", "pend cleared by reset", irq_pend, 1'b0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", "pend after second release", irq_pend, 1'b0);
        check("R1", "req after second release",  irq_req,  1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule